// File: doc/BRIEF.md
# Serial Lane Burst Sequencer

This block drives one forward-direction high-speed serial data lane. While idle it holds the low-power line pair at 11. On a request it steps the lane through a fixed entry sequence: low-power 01, then low-power 00, then a run of high-speed zeros. It then serialises a sync byte and a stream of payload bytes, one bit per clock. After the payload it holds the inverse of the final bit for a trail interval and returns the lane to low-power 11.

The clock runs at one unit interval (UI) per cycle. Each interval is set by a cycle-count parameter. At elaboration, each count is converted to time through `UI_PS` and checked against its line-level limit: low-power period at least 50 ns; prepare between 40 ns + 4 UI and 85 ns + 6 UI; prepare plus zero at least 145 ns + 10 UI; trail at least max(8 UI, 60 ns + 4 UI) and at most 105 ns + 12 UI; exit at least 100 ns. Payload bytes arrive on a valid/ready stream with a last-byte flag.

Top module: `lane_burst_seq`

## Requirements
- R1: Out of reset and while idle with no request, lp_dp_o=1, lp_dn_o=1, hs_en_o=0, hs_bit_o=0 and tx_ready_o=0.
- R2: A request sampled in idle makes the lane show (lp_dp_o,lp_dn_o)=(0,1) from the next cycle for LPX_CYC cycles, then (0,0) for PREP_CYC cycles, with hs_en_o=0 throughout.
- R3: After prepare, hs_en_o=1 and hs_bit_o=0 for ZERO_CYC cycles; whenever hs_en_o=1 both low-power outputs are 0.
- R4: The sync byte 8'hB8 follows the zeros, least significant bit first, one bit per cycle.
- R5: Each accepted payload byte follows on hs_bit_o least significant bit first, with no gap after sync or between bytes.
- R6: tx_ready_o is 1 only in the cycle of bit 7 of the sync byte, or in the cycle of bit 7 of a payload byte that was not flagged last; a byte is taken at a clock edge where tx_ready_o and tx_valid_i are both 1.
- R7: A byte taken with tx_last_i=1 is the final byte of the burst, and tx_ready_o stays 0 during it.
- R8: If tx_valid_i is 0 in a cycle where tx_ready_o is 1, the payload ends after the current byte (a burst with no payload when this happens on the sync byte).
- R9: After the final bit, hs_en_o stays 1 and hs_bit_o holds the inverse of that bit for TRAIL_CYC cycles.
- R10: After the trail, hs_en_o=0 and the lane shows (1,1) for EXIT_CYC cycles, then returns to idle for at least one cycle before any new entry.
- R11: A request sampled while the lane is not idle is held, and a new burst starts right after the one idle cycle that follows the exit interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one UI per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | 1 | Burst request |
| tx_data_i | input | 8 | Payload byte |
| tx_valid_i | input | 1 | Payload byte present |
| tx_last_i | input | 1 | Payload byte is the final one |
| tx_ready_o | output | 1 | Byte taken at the coming edge if valid |
| lp_dp_o | output | 1 | Low-power level, positive wire |
| lp_dn_o | output | 1 | Low-power level, negative wire |
| hs_en_o | output | 1 | High-speed driver enable |
| hs_bit_o | output | 1 | Serialised high-speed bit |

## Verification
The lane is driven with bursts that end on a last-flagged byte and with bursts that end because no byte is offered, including one that ends right after the sync byte. Comparing the two separates the last-flag path from the starvation path. Bytes of all zeros and all ones show whether the trail really inverts the final bit rather than holding a fixed level. Requests raised early in a burst and during the exit interval test that a pending request waits for the exit to finish. Random byte counts and contents, compared cycle by cycle against a waveform built in the bench, catch bit-order and byte-boundary slips.

// File: rtl/lbs_pkg.sv
// Package: shared state type and fixed constants for the lane burst sequencer.
// Assumes one UI per clock cycle and an 8-bit byte.
package lbs_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LP01,
        ST_LP00,
        ST_HSZ,
        ST_SYNC,
        ST_PAY,
        ST_TRAIL,
        ST_EXIT
    } lane_st_e;

    localparam int unsigned BYTE_W = 8;
    localparam logic [BYTE_W-1:0] SYNC_BYTE = 8'hB8;
endpackage

// File: rtl/lbs_interval_cnt.sv
// Interval counter: loads a remaining-cycle count and counts down to zero.
// Assumes the owner loads (duration-1) on the cycle it changes state.
module lbs_interval_cnt #(
    parameter int unsigned CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expired
);
    logic [CW-1:0] cnt;

    // Hold the remaining cycles of the current interval.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (load)       cnt <= load_val;
        else if (cnt != '0)  cnt <= cnt - CW'(1);
    end

    assign expired = (cnt == '0);

    // Intervals shrink by exactly one per cycle when not reloaded.
    assert_count_down_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt != '0) |=> (cnt == $past(cnt) - CW'(1)));
endmodule

// File: rtl/lbs_shifter.sv
// Byte shifter: outputs bit 0 first, flags the last bit of each loaded word.
// Assumes the owner reloads at a word boundary or stops shifting.
module lbs_shifter #(
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [DW-1:0] load_val,
    input  logic          shift,
    output logic          bit_o,
    output logic          word_end
);
    localparam int unsigned IW = $clog2(DW);

    logic [DW-1:0] sh;
    logic [IW-1:0] idx;

    // Load a new word or move the next bit into position 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh  <= '0;
            idx <= '0;
        end else if (load) begin
            sh  <= load_val;
            idx <= '0;
        end else if (shift) begin
            sh  <= sh >> 1;
            idx <= idx + IW'(1);
        end
    end

    assign bit_o    = sh[0];
    assign word_end = (idx == IW'(DW - 1));

    // Within a word, the next bit shown is the neighbour of the current one.
    assert_lsb_order_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (shift && !load && !word_end) |=> (bit_o == $past(sh[1])));
endmodule

// File: rtl/lane_burst_seq.sv
// Lane burst sequencer top: line-state FSM for entry, sync, payload, trail, exit.
// Assumes clk is the bit clock (one UI per cycle) and UI_PS gives its period.
module lane_burst_seq
    import lbs_pkg::*;
#(
    parameter int unsigned UI_PS     = 20000,
    parameter int unsigned LPX_CYC   = 3,
    parameter int unsigned PREP_CYC  = 7,
    parameter int unsigned ZERO_CYC  = 12,
    parameter int unsigned TRAIL_CYC = 8,
    parameter int unsigned EXIT_CYC  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic [BYTE_W-1:0] tx_data_i,
    input  logic              tx_valid_i,
    input  logic              tx_last_i,
    output logic              tx_ready_o,
    output logic              lp_dp_o,
    output logic              lp_dn_o,
    output logic              hs_en_o,
    output logic              hs_bit_o
);
    localparam int unsigned M1   = (LPX_CYC > PREP_CYC) ? LPX_CYC : PREP_CYC;
    localparam int unsigned M2   = (ZERO_CYC > TRAIL_CYC) ? ZERO_CYC : TRAIL_CYC;
    localparam int unsigned M3   = (M1 > M2) ? M1 : M2;
    localparam int unsigned MAXD = (M3 > EXIT_CYC) ? M3 : EXIT_CYC;
    localparam int unsigned CW   = $clog2(MAXD + 1);

    // Elaboration checks of every interval against its line-level limit.
    if (LPX_CYC * UI_PS < 50000) begin : g_lpx_short
        $error("low-power period below 50 ns");
    end
    if (PREP_CYC * UI_PS < 40000 + 4 * UI_PS) begin : g_prep_short
        $error("prepare below 40 ns + 4 UI");
    end
    if (PREP_CYC * UI_PS > 85000 + 6 * UI_PS) begin : g_prep_long
        $error("prepare above 85 ns + 6 UI");
    end
    if ((PREP_CYC + ZERO_CYC) * UI_PS < 145000 + 10 * UI_PS) begin : g_zero_short
        $error("prepare plus zero below 145 ns + 10 UI");
    end
    if (TRAIL_CYC < 8 || TRAIL_CYC * UI_PS < 60000 + 4 * UI_PS) begin : g_trail_short
        $error("trail below max(8 UI, 60 ns + 4 UI)");
    end
    if (TRAIL_CYC * UI_PS > 105000 + 12 * UI_PS) begin : g_trail_long
        $error("trail above 105 ns + 12 UI");
    end
    if (EXIT_CYC * UI_PS < 100000) begin : g_exit_short
        $error("exit below 100 ns");
    end

    lane_st_e          st, st_nx;
    logic              pend_q, last_q, trail_q;
    logic              expired, tmr_load;
    logic [CW-1:0]     tmr_val;
    logic              sh_load, sh_shift, sh_bit, word_end, take, in_hs_ser;
    logic [BYTE_W-1:0] sh_val;

    assign in_hs_ser  = (st == ST_SYNC) || (st == ST_PAY);
    assign tx_ready_o = word_end && ((st == ST_SYNC) || (st == ST_PAY && !last_q));
    assign take       = tx_ready_o && tx_valid_i;

    // Next-state selection for the lane sequence.
    always_comb begin
        st_nx = st;
        case (st)
            ST_IDLE:  if (req_i || pend_q) st_nx = ST_LP01;
            ST_LP01:  if (expired) st_nx = ST_LP00;
            ST_LP00:  if (expired) st_nx = ST_HSZ;
            ST_HSZ:   if (expired) st_nx = ST_SYNC;
            ST_SYNC,
            ST_PAY:   if (word_end) st_nx = take ? ST_PAY : ST_TRAIL;
            ST_TRAIL: if (expired) st_nx = ST_EXIT;
            ST_EXIT:  if (expired) st_nx = ST_IDLE;
            default:  st_nx = ST_IDLE;
        endcase
    end

    // Interval length for the state being entered.
    always_comb begin
        case (st_nx)
            ST_LP01:  tmr_val = CW'(LPX_CYC - 1);
            ST_LP00:  tmr_val = CW'(PREP_CYC - 1);
            ST_HSZ:   tmr_val = CW'(ZERO_CYC - 1);
            ST_TRAIL: tmr_val = CW'(TRAIL_CYC - 1);
            ST_EXIT:  tmr_val = CW'(EXIT_CYC - 1);
            default:  tmr_val = '0;
        endcase
    end
    assign tmr_load = (st_nx != st);

    lbs_interval_cnt #(.CW(CW)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (expired)
    );

    assign sh_load  = (st == ST_HSZ && st_nx == ST_SYNC) || take;
    assign sh_val   = take ? tx_data_i : SYNC_BYTE;
    assign sh_shift = in_hs_ser;

    lbs_shifter #(.DW(BYTE_W)) u_shf (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (sh_load),
        .load_val (sh_val),
        .shift    (sh_shift),
        .bit_o    (sh_bit),
        .word_end (word_end)
    );

    // State, pending request, last-byte flag and trail level registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= ST_IDLE;
            pend_q  <= 1'b0;
            last_q  <= 1'b0;
            trail_q <= 1'b0;
        end else begin
            st     <= st_nx;
            pend_q <= (st == ST_IDLE) ? 1'b0 : (pend_q || req_i);
            if (st_nx == ST_SYNC && st != ST_SYNC) last_q <= 1'b0;
            else if (take)                         last_q <= tx_last_i;
            if (in_hs_ser && st_nx == ST_TRAIL)    trail_q <= ~sh_bit;
        end
    end

    // Line outputs decoded from the current state.
    always_comb begin
        lp_dp_o  = 1'b0;
        lp_dn_o  = 1'b0;
        hs_en_o  = 1'b0;
        hs_bit_o = 1'b0;
        case (st)
            ST_IDLE, ST_EXIT: begin lp_dp_o = 1'b1; lp_dn_o = 1'b1; end
            ST_LP01:          lp_dn_o = 1'b1;
            ST_HSZ:           hs_en_o = 1'b1;
            ST_SYNC, ST_PAY:  begin hs_en_o = 1'b1; hs_bit_o = sh_bit; end
            ST_TRAIL:         begin hs_en_o = 1'b1; hs_bit_o = trail_q; end
            default:          ;
        endcase
    end

    // High-speed drive only ever starts from low-power 00.
    assert_hs_from_lp00_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_en_o) |-> $past(!lp_dp_o && !lp_dn_o));
    // Low-power wires are released while the high-speed driver is on.
    assert_hs_lp_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        hs_en_o |-> (!lp_dp_o && !lp_dn_o));
    // Ready is raised only while serialising.
    assert_ready_in_hs_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready_o |-> hs_en_o);
    // First trail cycle flips the final payload level.
    assert_trail_flip_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_TRAIL && $past(st) != ST_TRAIL) |-> (hs_bit_o != $past(hs_bit_o)));
    // High-speed drive always hands the lane back at low-power 11.
    assert_exit_lp11_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hs_en_o) |-> (lp_dp_o && lp_dn_o));
endmodule

// File: tb/lane_burst_seq_tb.sv
module lane_burst_seq_tb;
    localparam int LPX = 3, PREP = 7, ZERO = 12, TRAIL = 8, EXIT = 5;
    localparam logic [7:0] SYNC = 8'hB8;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst_n, req, valid, last, ready, dp, dn, en, hbit;
    logic [7:0] data;

    lane_burst_seq #(.UI_PS(20000), .LPX_CYC(LPX), .PREP_CYC(PREP), .ZERO_CYC(ZERO),
                     .TRAIL_CYC(TRAIL), .EXIT_CYC(EXIT)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_i(req), .tx_data_i(data), .tx_valid_i(valid),
        .tx_last_i(last), .tx_ready_o(ready), .lp_dp_o(dp), .lp_dn_o(dn),
        .hs_en_o(en), .hs_bit_o(hbit));

    int n_chk = 0, n_bad = 0;
    logic [4:0] exp_q[$];
    string tag_q[$];
    logic [7:0] dat [0:15];
    logic lst [0:15];
    int avail;

    task automatic push(input logic [4:0] v, input string t, input int n);
        repeat (n) begin exp_q.push_back(v); tag_q.push_back(t); end
    endtask

    // Expected {dp,dn,en,bit,ready} per cycle for one burst.
    task automatic add_burst(input int base, input int n, input bit by_last);
        logic lb;
        push(5'b01000, "R2", LPX);
        push(5'b00000, "R2", PREP);
        push(5'b00100, "R3", ZERO);
        for (int i = 0; i < 8; i++)
            push({3'b001, SYNC[i], i == 7}, (i == 7) ? "R6" : "R4", 1);
        lb = SYNC[7];
        for (int j = 0; j < n; j++) begin
            for (int i = 0; i < 8; i++) begin
                bit fin = by_last && (j == n - 1);
                push({3'b001, dat[base+j][i], (i == 7) && !fin},
                     (i != 7) ? "R5" : (fin ? "R7" : "R6"), 1);
            end
            lb = dat[base+j][7];
        end
        push({3'b001, ~lb, 1'b0}, by_last ? "R9" : "R8", TRAIL);
        push(5'b11000, "R10", EXIT);
    endtask

    task automatic check(input logic [4:0] e, input string t, input int k);
        logic [4:0] a;
        a = {dp, dn, en, hbit, ready};
        n_chk++;
        if (a !== e) begin
            n_bad++;
            $display("FAIL %s cycle %0d: actual=%b expected=%b", t, k, a, e);
        end
    endtask

    // Drive one sequence and compare every cycle at the falling edge.
    task automatic run_seq(input bit start, input int inject);
        int idx = 0;
        bit took = 1'b0;
        for (int k = 0; k < exp_q.size(); k++) begin
            @(posedge clk); #1;
            if (took) idx++;
            req   = (start && k == 0) || (k == inject);
            valid = (idx < avail);
            data  = dat[idx % 16];
            last  = lst[idx % 16];
            @(negedge clk);
            check(exp_q[k], tag_q[k], k);
            took = ready && valid;
        end
        @(posedge clk); #1;
        req = 1'b0; valid = 1'b0;
        exp_q.delete(); tag_q.delete();
    endtask

    task automatic clear_bytes();
        for (int i = 0; i < 16; i++) begin dat[i] = 8'h00; lst[i] = 1'b0; end
    endtask

    task automatic single(input int n, input bit by_last);
        avail = n;
        if (by_last && n > 0) lst[n-1] = 1'b1;
        push(5'b11000, "R1", 1);
        add_burst(0, n, by_last);
        push(5'b11000, "R10", 3);
        run_seq(1'b1, -1);
    endtask

    task automatic pending(input int n1, input int n2, input bit late);
        int inj;
        avail = n1 + n2;
        lst[n1-1] = 1'b1; lst[n1+n2-1] = 1'b1;
        push(5'b11000, "R1", 1);
        add_burst(0, n1, 1'b1);
        push(5'b11000, "R11", 1);
        add_burst(n1, n2, 1'b1);
        push(5'b11000, "R10", 2);
        inj = late ? (1 + LPX + PREP + ZERO + 8 + 8*n1 + TRAIL + 1) : 4;
        run_seq(1'b1, inj);
    endtask

    initial begin
        void'($urandom(32'h00C0FFEE));
        rst_n = 1'b0; req = 1'b0; valid = 1'b0; last = 1'b0; data = 8'h00; avail = 0;
        clear_bytes();
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(5'b11000, "R1", -1);
        @(posedge clk); #1 rst_n = 1'b1;
        // R1: idle without request
        avail = 0; push(5'b11000, "R1", 6); run_seq(1'b0, -1);
        // R7 and R9: single zero byte, trail must be 1
        clear_bytes(); single(1, 1'b1);
        // R5: all-ones then mixed byte
        clear_bytes(); dat[0] = 8'hFF; dat[1] = 8'h5A; single(2, 1'b1);
        clear_bytes(); dat[0] = 8'hFF; single(1, 1'b1);
        // R8: starvation right after sync, then after three bytes
        clear_bytes(); single(0, 1'b0);
        clear_bytes(); for (int i = 0; i < 3; i++) dat[i] = 8'($urandom); single(3, 1'b0);
        // R11: request during entry and during exit
        clear_bytes(); for (int i = 0; i < 3; i++) dat[i] = 8'($urandom); pending(1, 2, 1'b0);
        clear_bytes(); for (int i = 0; i < 4; i++) dat[i] = 8'($urandom); pending(2, 2, 1'b1);
        // Random bursts
        for (int r = 0; r < 25; r++) begin
            int n;
            bit bl;
            clear_bytes();
            n  = 1 + int'($urandom % 4);
            bl = 1'($urandom);
            for (int i = 0; i < n; i++) dat[i] = 8'($urandom);
            single(n, bl);
        end
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL R1 watchdog: actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule